// File: doc/BRIEF.md
# Atomic Context Save Sequencer

This block holds a set of secure state sections and, on a single context-save command from software, writes them all out to memory as a fixed series of 128-bit blocks. Each block goes to the address `BASE_ADDR + 16 * index`. The engine waits whenever the memory port applies backpressure. A running block counter lets software check afterwards that the whole image went out. The block contents here are synthetic: each block carries its section code, its offset inside the section and its global index. They stand in for real key material.

Software drives a small register port with five registers, all write-through and read combinationally:

| Word | Register | Contents |
|------|----------|----------|
| 0 | auto-save control | enable, lock, progress counter |
| 1 | operation | command field |
| 2 | status | busy indicator |
| 3 | interrupt | operation-done flag |
| 4 | error | rejected-command flag |

The enable bit can be changed freely until the lock bit is set. Once the lock bit is set, the lock stays set and the enable bit can no longer be changed.

The parameter `EXTENDED` picks one of two save layouts.

| Layout | Blocks | Sections, in order |
|--------|--------|--------------------|
| Base (`EXTENDED=0`) | 133 | one random-data block, two sticky-bit blocks, a 64-block key table, 64 RSA-key blocks, one pad block, one known-pattern block |
| Extended (`EXTENDED=1`) | 646 | the base sections up to the RSA keys, then one public-key sticky block and 512 public-key blocks, then the pad block and the known-pattern block |

The key table holds 16 entries. Each entry is written as two key blocks, then its original IV block, then its updated IV block.

The controller has two states:

- `ST_IDLE`: waits for a command. An accepted context-save command moves the controller to `ST_STREAM`.
- `ST_STREAM`: presents one block at a time. When a block is accepted, the controller advances to the next index. When the last block is accepted, it returns to `ST_IDLE`.

Top module: `ctx_save_seq`

## Requirements
- R1: After reset, every register reads 0 and `mem_valid` is 0.
- R2: The control register (word 0) has enable at bit 0, lock at bit 8 and a read-only 10-bit count at bits 25:16.
  - While the register is unlocked, a write sets enable from bit 0.
  - A write with bit 8 set sets lock. Lock then stays set until reset.
  - While locked, writes leave enable unchanged.
- R3: Writing command code 3 to word 1 bits 2:0 while enable is 0 writes no block. It also leaves status at 0 and sets error bit 0 (word 4). Writing 1 to that error bit clears it.
- R4: Status (word 2, bits 1:0) reads 1 from the cycle after an accepted save until the last block is accepted, and 0 otherwise.
- R5: The data fields of a block are:
  - bits 123:120: section code
  - bits 119:104: offset in the section
  - bits 103:96: zero
  - bits 95:0: the 16-bit global index repeated six times, except in the random block

  The base layout is written in this order:

  | Indices | Section | Code |
  |---------|---------|------|
  | 0 | random | 1 |
  | 1–2 | sticky | 2 |
  | 3–66 | key table | 3/4/5 |
  | 67–130 | RSA | 6 |
  | 131 | pad | 9 |
  | 132 | known pattern (the whole 128 bits equal `KNOWN_PATTERN`) | — |
- R6: Inside the key table, each of the 16 entries is written as key (code 3), key (code 3), original IV (code 4), updated IV (code 5). The offset field counts 0–63 across the whole table.
- R7: With `EXTENDED=1`, the RSA section is followed by one public-key sticky block (code 7) and 512 public-key blocks (code 8). After those come the pad block and the known pattern, for 646 blocks in total.
- R8: Each block is written once per `mem_valid`/`mem_ready` handshake at `BASE_ADDR + 16*index`. While `mem_ready` is low, the address and data are held.
- R9: The count increases by one for each accepted block. After one complete save from zero, it equals the layout size.
- R10: Acceptance of the last block sets the done flag (word 3, bit 4). Writing 1 to bit 4 clears it, and writing 0 to it has no effect.
- R11: Command code 3 written while a save is running is rejected: it sets error bit 0 and leaves the running stream and the count unaffected.
- R12: Command codes 0, 1, 2 and 4 have no effect: no block is written, status stays 0 and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_valid | output | 1 | Block write request |
| mem_ready | input | 1 | Memory accepts the block this cycle |
| mem_addr | output | AW | Block byte address |
| mem_data | output | 128 | Block contents |

## Verification
The assertions check several properties on every cycle:
- Address and data stay stable under backpressure.
- The count moves by exactly one on each accepted block and holds otherwise.
- The lock stays set, and enable cannot move while locked.
- The done flag follows the last handshake.
- A save command issued while disabled never starts a stream.

The following are shown only by the bench scenarios, which compare every block against an independently built expected image under varied backpressure:
- the full section order of both layouts, including the key-table interleaving;
- the final count equal to the layout size;
- the no-effect commands;
- the rejection of a second save during a stream.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;

    localparam int RAND_BLKS      = 1;
    localparam int STICKY_BLKS    = 2;
    localparam int KEY_ENTRIES    = 16;
    localparam int BLKS_PER_KEY   = 4;
    localparam int KTAB_BLKS      = KEY_ENTRIES * BLKS_PER_KEY;
    localparam int RSA_BLKS       = 64;
    localparam int PK_STICKY_BLKS = 1;
    localparam int PK_KEY_BLKS    = 512;
    localparam int PAD_BLKS       = 1;
    localparam int PATTERN_BLKS   = 1;

    typedef enum logic [3:0] {
        SEC_NONE      = 4'd0,
        SEC_RANDOM    = 4'd1,
        SEC_STICKY    = 4'd2,
        SEC_KEY       = 4'd3,
        SEC_IV_ORIG   = 4'd4,
        SEC_IV_UPD    = 4'd5,
        SEC_RSA       = 4'd6,
        SEC_PK_STICKY = 4'd7,
        SEC_PK_KEY    = 4'd8,
        SEC_PAD       = 4'd9,
        SEC_PATTERN   = 4'd15
    } sect_e;

    typedef enum logic [2:0] {
        CMD_ABORT      = 3'd0,
        CMD_START      = 3'd1,
        CMD_RESTART    = 3'd2,
        CMD_CTX_SAVE   = 3'd3,
        CMD_RESTART_IN = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        RA_AUTO   = 3'd0,
        RA_OP     = 3'd1,
        RA_STATUS = 3'd2,
        RA_INTR   = 3'd3,
        RA_ERR    = 3'd4
    } reg_word_e;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } seq_state_e;

    function automatic int layout_blocks(bit ext);
        int n;
        n = RAND_BLKS + STICKY_BLKS + KTAB_BLKS + RSA_BLKS + PAD_BLKS + PATTERN_BLKS;
        if (ext) n = n + PK_STICKY_BLKS + PK_KEY_BLKS;
        return n;
    endfunction

endpackage

// File: rtl/ctx_lfsr.sv
module ctx_lfsr #(
    parameter int         W    = 32,
    parameter logic [W-1:0] TAPS = 32'h8020_0003,
    parameter logic [W-1:0] SEED = 32'h1357_9BDF
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= SEED;
        end else begin
            value <= {value[W-2:0], 1'b0} ^ (value[W-1] ? TAPS : '0);
        end
    end

endmodule

// File: rtl/ctx_layout.sv
module ctx_layout import ctx_save_pkg::*; #(
    parameter bit EXTENDED = 1'b0,
    parameter int IW       = 8
) (
    input  logic [IW-1:0] idx,
    output sect_e         tag,
    output logic [15:0]   sub
);

    localparam int O_STICKY = RAND_BLKS;
    localparam int O_KTAB   = O_STICKY + STICKY_BLKS;
    localparam int O_RSA    = O_KTAB + KTAB_BLKS;
    localparam int O_TAIL   = O_RSA + RSA_BLKS;
    localparam int O_PKS    = O_TAIL;
    localparam int O_PKK    = O_PKS + PK_STICKY_BLKS;
    localparam int O_PAD    = EXTENDED ? (O_PKK + PK_KEY_BLKS) : O_TAIL;
    localparam int O_PAT    = O_PAD + PAD_BLKS;

    int   pos;
    logic pk_hit;
    sect_e pk_tag;
    logic [15:0] pk_sub;

    assign pos = int'(idx);

    generate
        if (EXTENDED) begin : g_pk
            always_comb begin
                pk_hit = (pos >= O_PKS) && (pos < O_PAD);
                if (pos < O_PKK) begin
                    pk_tag = SEC_PK_STICKY;
                    pk_sub = 16'(pos - O_PKS);
                end else begin
                    pk_tag = SEC_PK_KEY;
                    pk_sub = 16'(pos - O_PKK);
                end
            end
        end else begin : g_nopk
            assign pk_hit = 1'b0;
            assign pk_tag = SEC_NONE;
            assign pk_sub = 16'd0;
        end
    endgenerate

    always_comb begin
        tag = SEC_NONE;
        sub = 16'd0;
        if (pos < O_STICKY) begin
            tag = SEC_RANDOM;
        end else if (pos < O_KTAB) begin
            tag = SEC_STICKY;
            sub = 16'(pos - O_STICKY);
        end else if (pos < O_RSA) begin
            sub = 16'(pos - O_KTAB);
            unique case (sub[1:0])
                2'd0, 2'd1: tag = SEC_KEY;
                2'd2:       tag = SEC_IV_ORIG;
                default:    tag = SEC_IV_UPD;
            endcase
        end else if (pos < O_TAIL) begin
            tag = SEC_RSA;
            sub = 16'(pos - O_RSA);
        end else if (pk_hit) begin
            tag = pk_tag;
            sub = pk_sub;
        end else if (pos < O_PAT) begin
            tag = SEC_PAD;
            sub = 16'(pos - O_PAD);
        end else begin
            tag = SEC_PATTERN;
        end
    end

endmodule

// File: rtl/ctx_regs.sv
module ctx_regs import ctx_save_pkg::*; #(
    parameter int CW = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    input  logic        busy,
    input  logic        blk_accept,
    input  logic        save_done,
    input  logic        reject,
    output logic        enable,
    output logic [31:0] rdata
);

    logic          en_q;
    logic          lock_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          err_q;
    logic          wr_auto, wr_intr, wr_err;

    assign wr_auto = wr_en && (addr == RA_AUTO);
    assign wr_intr = wr_en && (addr == RA_INTR);
    assign wr_err  = wr_en && (addr == RA_ERR);
    assign enable  = en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            lock_q <= 1'b0;
            cnt_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (wr_auto) begin
                if (!lock_q)  en_q   <= wdata[0];
                if (wdata[8]) lock_q <= 1'b1;
            end
            if (blk_accept) cnt_q <= cnt_q + 1'b1;
            if (save_done)                done_q <= 1'b1;
            else if (wr_intr && wdata[4]) done_q <= 1'b0;
            if (reject)                   err_q  <= 1'b1;
            else if (wr_err && wdata[0])  err_q  <= 1'b0;
        end
    end

    always_comb begin
        rdata = 32'd0;
        case (addr)
            RA_AUTO: begin
                rdata[0]     = en_q;
                rdata[8]     = lock_q;
                rdata[25:16] = 10'(cnt_q);
            end
            RA_STATUS: rdata[1:0] = {1'b0, busy};
            RA_INTR:   rdata[4]   = done_q;
            RA_ERR:    rdata[0]   = err_q;
            default:   rdata      = 32'd0;
        endcase
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);  // R2
    AST_LOCKED_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(en_q));  // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        blk_accept |=> (cnt_q == $past(cnt_q) + 1'b1));  // R9
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_accept |=> $stable(cnt_q));  // R9
    AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        save_done |=> done_q);  // R10

endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq import ctx_save_pkg::*; #(
    parameter bit             EXTENDED      = 1'b0,
    parameter int             AW            = 32,
    parameter logic [AW-1:0]  BASE_ADDR     = 32'h4000_0000,
    parameter logic [127:0]   KNOWN_PATTERN = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0,
    parameter int             CW            = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [127:0]  mem_data
);

    localparam int TOTAL = layout_blocks(EXTENDED);
    localparam int IW    = $clog2(TOTAL);
    localparam logic [IW-1:0] LAST_IDX = IW'(TOTAL - 1);

    seq_state_e    state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [31:0]   rnd_q, rnd_live;
    logic          enable, busy, blk_accept, save_done;
    logic          save_req, start, reject;
    sect_e         tag;
    logic [15:0]   sub;
    logic [15:0]   gidx;

    ctx_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd_live)
    );

    ctx_layout #(.EXTENDED(EXTENDED), .IW(IW)) u_layout (
        .idx (idx_q),
        .tag (tag),
        .sub (sub)
    );

    ctx_regs #(.CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .busy       (busy),
        .blk_accept (blk_accept),
        .save_done  (save_done),
        .reject     (reject),
        .enable     (enable),
        .rdata      (reg_rdata)
    );

    assign save_req = reg_wr && (reg_addr == RA_OP) && (reg_wdata[2:0] == CMD_CTX_SAVE);
    assign start    = save_req && enable && (state_q == ST_IDLE);
    assign reject   = save_req && !start;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            rnd_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (start) rnd_q <= rnd_live;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_STREAM;
                    idx_d   = '0;
                end
            end
            ST_STREAM: begin
                if (mem_ready) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_IDLE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_valid  = 1'b0;
        busy       = 1'b0;
        blk_accept = 1'b0;
        save_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                mem_valid = 1'b0;
            end
            ST_STREAM: begin
                mem_valid  = 1'b1;
                busy       = 1'b1;
                blk_accept = mem_ready;
                save_done  = mem_ready && (idx_q == LAST_IDX);
            end
            default: mem_valid = 1'b0;
        endcase
    end

    assign gidx     = 16'(idx_q);
    assign mem_addr = BASE_ADDR + (AW'(idx_q) << 4);

    always_comb begin
        if (tag == SEC_PATTERN) begin
            mem_data = KNOWN_PATTERN;
        end else if (tag == SEC_RANDOM) begin
            mem_data = {4'h0, tag, sub, 8'h00, rnd_q, ~rnd_q, rnd_q ^ 32'h5A5A_5A5A};
        end else begin
            mem_data = {4'h0, tag, sub, 8'h00, {6{gidx}}};
        end
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));  // R8
    AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !enable && !mem_valid) |=> !mem_valid);  // R3

endmodule

// File: tb/ctx_save_seq_tb.sv
module ctx_save_seq_tb;

    localparam logic [127:0] KP      = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
    localparam logic [31:0]  B_BASE  = 32'h4000_0000;
    localparam logic [31:0]  X_BASE  = 32'h8000_0000;

    typedef struct {
        logic [31:0]  a;
        logic [127:0] d;
        logic [127:0] m;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        b_wr = 0, x_wr = 0;
    logic [2:0]  b_addr = 0, x_addr = 0;
    logic [31:0] b_wdata = 0, x_wdata = 0;
    logic [31:0] b_rdata, x_rdata;
    logic        b_valid, x_valid;
    logic        b_ready = 0, x_ready = 0;
    logic [31:0] b_maddr, x_maddr;
    logic [127:0] b_mdata, x_mdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int b_mode = 1, x_mode = 1;
    logic [15:0] tb_lfsr = 16'hACE1;
    item_t bq[$];
    item_t xq[$];

    ctx_save_seq #(.EXTENDED(1'b0), .BASE_ADDR(B_BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(b_wr), .reg_addr(b_addr),
        .reg_wdata(b_wdata), .reg_rdata(b_rdata), .mem_valid(b_valid),
        .mem_ready(b_ready), .mem_addr(b_maddr), .mem_data(b_mdata));

    ctx_save_seq #(.EXTENDED(1'b1), .BASE_ADDR(X_BASE)) u_ext (
        .clk(clk), .rst_n(rst_n), .reg_wr(x_wr), .reg_addr(x_addr),
        .reg_wdata(x_wdata), .reg_rdata(x_rdata), .mem_valid(x_valid),
        .mem_ready(x_ready), .mem_addr(x_maddr), .mem_data(x_mdata));

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic pick(int mode, logic r);
        case (mode)
            0: return 1'b0;
            1: return 1'b1;
            default: return r;
        endcase
    endfunction

    // ready driver: changes just after each rising edge
    always @(posedge clk) begin
        #1;
        tb_lfsr = {tb_lfsr[14:0], tb_lfsr[15] ^ tb_lfsr[13] ^ tb_lfsr[12] ^ tb_lfsr[10]};
        b_ready = pick(b_mode, tb_lfsr[0]);
        x_ready = pick(x_mode, tb_lfsr[3]);
    end

    // scoreboard driver side
    task automatic push_one(input bit ext, input int n, input logic [3:0] tg, input int sb, input bit is_rand);
        item_t it;
        logic [15:0] g;
        g = 16'(n);
        it.a = (ext ? X_BASE : B_BASE) + 32'(n * 16);
        it.d = {4'h0, tg, 16'(sb), 8'h00, {6{g}}};
        it.m = is_rand ? {32'hFFFF_FFFF, 96'd0} : {128{1'b1}};
        if (ext) xq.push_back(it); else bq.push_back(it);
    endtask

    task automatic push_layout(input bit ext);
        int n;
        item_t it;
        n = 0;
        push_one(ext, n, 4'd1, 0, 1'b1); n++;
        for (int s = 0; s < 2; s++) begin push_one(ext, n, 4'd2, s, 1'b0); n++; end
        for (int e = 0; e < 16; e++) begin
            for (int p = 0; p < 4; p++) begin
                push_one(ext, n, (p < 2) ? 4'd3 : ((p == 2) ? 4'd4 : 4'd5), e * 4 + p, 1'b0);
                n++;
            end
        end
        for (int r = 0; r < 64; r++) begin push_one(ext, n, 4'd6, r, 1'b0); n++; end
        if (ext) begin
            push_one(ext, n, 4'd7, 0, 1'b0); n++;
            for (int k = 0; k < 512; k++) begin push_one(ext, n, 4'd8, k, 1'b0); n++; end
        end
        push_one(ext, n, 4'd9, 0, 1'b0); n++;
        it.a = (ext ? X_BASE : B_BASE) + 32'(n * 16);
        it.d = KP;
        it.m = {128{1'b1}};
        if (ext) xq.push_back(it); else bq.push_back(it);
    endtask

    // scoreboard monitor side: a handshake seen at the falling edge completes at the next rising edge
    always @(negedge clk) begin
        if (rst_n && b_valid && b_ready) begin
            if (bq.size() == 0) begin
                chk(1'b0, "R3 R12 unexpected block write", {96'd0, b_maddr}, 128'd0);
            end else begin
                item_t it;
                it = bq.pop_front();
                chk(b_maddr == it.a, "R8 block address", {96'd0, b_maddr}, {96'd0, it.a});
                chk((b_mdata & it.m) == (it.d & it.m), "R5 R6 block contents", b_mdata & it.m, it.d & it.m);
            end
        end
        if (rst_n && x_valid && x_ready) begin
            if (xq.size() == 0) begin
                chk(1'b0, "R7 unexpected block write", {96'd0, x_maddr}, 128'd0);
            end else begin
                item_t it;
                it = xq.pop_front();
                chk(x_maddr == it.a, "R8 R7 block address", {96'd0, x_maddr}, {96'd0, it.a});
                chk((x_mdata & it.m) == (it.d & it.m), "R7 block contents", x_mdata & it.m, it.d & it.m);
            end
        end
    end

    task automatic wr(input bit ext, input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        if (ext) begin x_wr = 1; x_addr = a; x_wdata = d; end
        else     begin b_wr = 1; b_addr = a; b_wdata = d; end
        @(posedge clk); #1;
        b_wr = 0; x_wr = 0;
    endtask

    task automatic rd(input bit ext, input logic [2:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        if (ext) x_addr = a; else b_addr = a;
        @(negedge clk);
        v = ext ? x_rdata : b_rdata;
    endtask

    task automatic wait_idle(input bit ext);
        logic [31:0] v;
        int n;
        n = 0;
        v = 32'd1;
        while (v[0] && n < 20000) begin
            rd(ext, 3'd2, v);
            n++;
        end
        chk(v[0] == 1'b0, "R4 save reaches idle", {96'd0, v}, 128'd0);
    endtask

    function automatic logic [127:0] ctl(int cnt, bit lk, bit en);
        logic [31:0] v;
        v = 32'd0;
        v[25:16] = 10'(cnt);
        v[8] = lk;
        v[0] = en;
        return {96'd0, v};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(1'b0, 3'(a), v);
            chk(v == 32'd0, "R1 register after reset", {96'd0, v}, 128'd0);
        end
        chk(b_valid == 1'b0, "R1 mem_valid after reset", {127'd0, b_valid}, 128'd0);

        // R3 save while disabled
        b_mode = 1;
        wr(1'b0, 3'd1, 32'd3);
        rd(1'b0, 3'd2, v); chk(v == 0, "R3 status stays idle", {96'd0, v}, 128'd0);
        rd(1'b0, 3'd4, v); chk(v == 1, "R3 error set", {96'd0, v}, 128'd1);
        rd(1'b0, 3'd0, v); chk({96'd0, v} == ctl(0, 0, 0), "R3 count unchanged", {96'd0, v}, ctl(0, 0, 0));
        wr(1'b0, 3'd4, 32'd1);
        rd(1'b0, 3'd4, v); chk(v == 0, "R3 error cleared", {96'd0, v}, 128'd0);

        // R2 unlocked enable toggle (done before R12 so enable is set there)
        wr(1'b0, 3'd0, 32'h1);
        rd(1'b0, 3'd0, v); chk({96'd0, v} == ctl(0, 0, 1), "R2 enable set", {96'd0, v}, ctl(0, 0, 1));
        wr(1'b0, 3'd0, 32'h0);
        rd(1'b0, 3'd0, v); chk({96'd0, v} == ctl(0, 0, 0), "R2 enable cleared unlocked", {96'd0, v}, ctl(0, 0, 0));
        wr(1'b0, 3'd0, 32'h101);
        rd(1'b0, 3'd0, v); chk({96'd0, v} == ctl(0, 1, 1), "R2 enable and lock", {96'd0, v}, ctl(0, 1, 1));
        wr(1'b0, 3'd0, 32'h0);
        rd(1'b0, 3'd0, v); chk({96'd0, v} == ctl(0, 1, 1), "R2 locked write ignored", {96'd0, v}, ctl(0, 1, 1));

        // R12 other commands with enable set
        wr(1'b0, 3'd1, 32'd0);
        wr(1'b0, 3'd1, 32'd1);
        wr(1'b0, 3'd1, 32'd2);
        wr(1'b0, 3'd1, 32'd4);
        rd(1'b0, 3'd2, v); chk(v == 0, "R12 status idle", {96'd0, v}, 128'd0);
        rd(1'b0, 3'd0, v); chk({96'd0, v} == ctl(0, 1, 1), "R12 count unchanged", {96'd0, v}, ctl(0, 1, 1));
        rd(1'b0, 3'd4, v); chk(v == 0, "R12 no error", {96'd0, v}, 128'd0);

        // base save, initially stalled
        b_mode = 0;
        @(posedge clk); #1;
        push_layout(1'b0);
        wr(1'b0, 3'd1, 32'd3);
        rd(1'b0, 3'd2, v); chk(v == 1, "R4 busy during save", {96'd0, v}, 128'd1);
        wr(1'b0, 3'd1, 32'd3);
        rd(1'b0, 3'd4, v); chk(v == 1, "R11 second save rejected", {96'd0, v}, 128'd1);
        rd(1'b0, 3'd2, v); chk(v == 1, "R11 stream still busy", {96'd0, v}, 128'd1);
        b_mode = 3;
        wait_idle(1'b0);
        rd(1'b0, 3'd0, v); chk({96'd0, v} == ctl(133, 1, 1), "R9 count after base save", {96'd0, v}, ctl(133, 1, 1));
        chk(bq.size() == 0, "R5 all blocks seen", 128'(bq.size()), 128'd0);
        rd(1'b0, 3'd3, v); chk(v == 32'h10, "R10 done flag set", {96'd0, v}, 128'h10);
        wr(1'b0, 3'd3, 32'h0);
        rd(1'b0, 3'd3, v); chk(v == 32'h10, "R10 write zero keeps done", {96'd0, v}, 128'h10);
        wr(1'b0, 3'd3, 32'h10);
        rd(1'b0, 3'd3, v); chk(v == 32'h0, "R10 done cleared", {96'd0, v}, 128'h0);
        wr(1'b0, 3'd4, 32'h1);
        rd(1'b0, 3'd4, v); chk(v == 0, "R11 error cleared", {96'd0, v}, 128'd0);

        // extended layout
        x_mode = 3;
        wr(1'b1, 3'd0, 32'h101);
        push_layout(1'b1);
        wr(1'b1, 3'd1, 32'd3);
        wait_idle(1'b1);
        rd(1'b1, 3'd0, v); chk({96'd0, v} == ctl(646, 1, 1), "R7 R9 count after extended save", {96'd0, v}, ctl(646, 1, 1));
        chk(xq.size() == 0, "R7 all blocks seen", 128'(xq.size()), 128'd0);
        rd(1'b1, 3'd3, v); chk(v == 32'h10, "R10 extended done", {96'd0, v}, 128'h10);
        rd(1'b1, 3'd4, v); chk(v == 0, "R7 no error", {96'd0, v}, 128'd0);

        repeat (4) @(posedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule